// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block holds both ends of a request/acknowledge bus. An initiator FSM and a responder FSM run on one clock, yet each treats the other's handshake line as unrelated to its own clock. Every handshake line is brought in through a multi-flop synchroniser on the receiving side. A command accepted at the local port puts the address, the direction and (for a write) the write data on the bus. These lines settle for a fixed number of cycles, and only then does request go high. Request and acknowledge then complete a full rise/rise/fall/fall sequence.

The responder owns a small word store that covers a window of the address space. A write is taken into the store before acknowledge rises. A read drives the store word onto the return lines one cycle before acknowledge rises. The initiator captures the return data in the cycle it drops request. An address outside the window is never answered. In that case the initiator gives up after a bounded wait and reports a bus error.

Top module: `hs_link_top`

## Requirements
- R1: After reset, request, acknowledge, bus_valid, busy, done and err are all low.
- R2: From the cycle a command is accepted until its done pulse, address, direction and write data on the bus stay constant.
- R3: Request rises exactly DECODE_CYC cycles after the bus lines become valid, never earlier.
- R4: A write to a word inside the window [BASE, BASE+WORDS) is stored at index addr-BASE. The responder stores it before it raises acknowledge. A later read of that address returns the value.
- R5: On a read, the return data is stable on the bus for at least one cycle before acknowledge rises. The value reported on rdata with done equals the stored word.
- R6: Acknowledge rises only while request is high. Request falls only after acknowledge has been seen or the timeout has expired. Acknowledge falls only after request has fallen.
- R7: A new command drives the bus only while acknowledge is low.
- R8: For an address outside the window, acknowledge never rises. Done comes with err=1 DECODE_CYC+TIMEOUT+1 cycles after acceptance, and the store is left unchanged.
- R9: With S synchroniser stages, done is a one-cycle pulse. It is first visible DECODE_CYC+4*S+4 cycles after the accepting edge for a write, and one cycle later for a read. err is 0 for an in-window access.
- R10: A start pulse while busy is high is ignored. It produces no done and no store update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Accept a command (when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Target address |
| wdata | input | DW | Write data |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rdata | output | DW | Read result, valid with done on a read |
| bus_valid | output | 1 | Address/direction/data lines are being driven |
| bus_req | output | 1 | Request line |
| bus_ack | output | 1 | Acknowledge line |

## Verification
The result of an operation is due on a cycle fixed by the parameters, counted from the edge that accepts start. With the defaults (DECODE_CYC=2, two stages) that is 14 cycles for a write, 15 for a read and 67 for a timeout. Each of the four crossings adds three cycles: two for the synchroniser and one for the reacting FSM. The driver task records the cycle count when it raises start and pushes the expected latency, error flag and read value into a queue. A monitor samples on the falling clock edge, pops the queue on each done pulse and compares the latency exactly. A done pulse with nothing queued also counts as a failure, which is how the ignored start is caught.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;
   typedef enum logic [1:0] {
      M_IDLE   = 2'd0,
      M_SETTLE = 2'd1,
      M_REQ    = 2'd2,
      M_REL    = 2'd3
   } init_state_t;

   typedef enum logic [1:0] {
      S_IDLE    = 2'd0,
      S_PRESENT = 2'd1,
      S_HOLD    = 2'd2
   } resp_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("hs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_initiator.sv
module hs_initiator
   import hs_link_pkg::*;
#(
   parameter int AW         = 8,
   parameter int DW         = 16,
   parameter int DECODE_CYC = 2,
   parameter int TIMEOUT    = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [DW-1:0] rdata,
   output logic          bus_valid,
   output logic          bus_wr,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_req,
   input  logic          ack_s,
   input  logic [DW-1:0] bus_rdata
);
   localparam int MAXC = (TIMEOUT > DECODE_CYC) ? TIMEOUT : DECODE_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (DECODE_CYC < 1) begin : g_bad_dec
         $error("hs_initiator: DECODE_CYC must be at least 1");
      end
      if (TIMEOUT < 2) begin : g_bad_to
         $error("hs_initiator: TIMEOUT must be at least 2");
      end
   endgenerate

   init_state_t      st;
   logic [CW-1:0]    cnt;
   logic             err_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= M_IDLE;
         cnt       <= '0;
         err_pend  <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         rdata     <= '0;
         bus_valid <= 1'b0;
         bus_wr    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         bus_req   <= 1'b0;
      end else begin
         unique case (st)
            M_IDLE: begin
               done <= 1'b0;
               err  <= 1'b0;
               if (start) begin
                  bus_valid <= 1'b1;
                  bus_wr    <= wr;
                  bus_addr  <= addr;
                  bus_wdata <= wdata;
                  err_pend  <= 1'b0;
                  cnt       <= CW'(DECODE_CYC);
                  st        <= M_SETTLE;
               end
            end
            M_SETTLE: begin
               if (cnt == CW'(1)) begin
                  bus_req <= 1'b1;
                  cnt     <= '0;
                  st      <= M_REQ;
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            M_REQ: begin
               if (ack_s) begin
                  bus_req <= 1'b0;
                  if (!bus_wr) rdata <= bus_rdata;
                  st <= M_REL;
               end else if (cnt == CW'(TIMEOUT - 1)) begin
                  bus_req  <= 1'b0;
                  err_pend <= 1'b1;
                  st       <= M_REL;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            M_REL: begin
               if (!ack_s) begin
                  done      <= 1'b1;
                  err       <= err_pend;
                  bus_valid <= 1'b0;
                  st        <= M_IDLE;
               end
            end
            default: st <= M_IDLE;
         endcase
      end
   end

   assign busy = (st != M_IDLE);

   AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && $past(bus_valid)) |-> ($stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata))); // R2
   AST_REQ_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(bus_valid)); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_REQ_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |-> ($past(ack_s) || err_pend)); // R6
endmodule

// File: rtl/hs_responder.sv
module hs_responder
   import hs_link_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int BASE  = 64,
   parameter int WORDS = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_s,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          bus_ack
);
   localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam logic [AW:0] LO = (AW+1)'(BASE);
   localparam logic [AW:0] HI = (AW+1)'(BASE + WORDS);

   generate
      if (BASE + WORDS > (1 << AW)) begin : g_bad_win
         $error("hs_responder: window exceeds address space");
      end
      if (WORDS < 1) begin : g_bad_words
         $error("hs_responder: WORDS must be at least 1");
      end
   endgenerate

   resp_state_t   st;
   logic [DW-1:0] store [WORDS];
   logic          hit;
   logic [IW-1:0] idx;

   assign hit = ({1'b0, bus_addr} >= LO) && ({1'b0, bus_addr} < HI);
   assign idx = IW'(bus_addr - AW'(BASE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
         for (int i = 0; i < WORDS; i++) store[i] <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (req_s && hit) begin
                  if (bus_wr) begin
                     store[idx] <= bus_wdata;
                     bus_ack    <= 1'b1;
                     st         <= S_HOLD;
                  end else begin
                     bus_rdata <= store[idx];
                     st        <= S_PRESENT;
                  end
               end
            end
            S_PRESENT: begin
               bus_ack <= 1'b1;
               st      <= S_HOLD;
            end
            S_HOLD: begin
               if (!req_s) begin
                  bus_ack <= 1'b0;
                  st      <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   AST_ACK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ack) |-> hit); // R8
   AST_READ_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_ack) && !bus_wr) |-> $stable(bus_rdata)); // R5
   AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ack && req_s) |=> bus_ack); // R6
endmodule

// File: rtl/hs_link_top.sv
module hs_link_top #(
   parameter int AW          = 8,
   parameter int DW          = 16,
   parameter int DECODE_CYC  = 2,
   parameter int TIMEOUT     = 64,
   parameter int BASE        = 64,
   parameter int WORDS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [DW-1:0] rdata,
   output logic          bus_valid,
   output logic          bus_req,
   output logic          bus_ack
);
   logic          bus_wr;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata;
   logic          req_s;
   logic          ack_s;

   hs_initiator #(
      .AW(AW), .DW(DW), .DECODE_CYC(DECODE_CYC), .TIMEOUT(TIMEOUT)
   ) u_init (
      .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr), .wdata(wdata),
      .busy(busy), .done(done), .err(err), .rdata(rdata),
      .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_req(bus_req), .ack_s(ack_s), .bus_rdata(bus_rdata)
   );

   hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_req), .q(req_s)
   );

   hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_s)
   );

   hs_responder #(
      .AW(AW), .DW(DW), .BASE(BASE), .WORDS(WORDS)
   ) u_resp (
      .clk(clk), .rst_n(rst_n), .req_s(req_s), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
   );

   AST_ACK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ack) |-> bus_req); // R6
   AST_ACK_FALL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_ack) |-> !bus_req); // R6
   AST_NEW_CMD_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_valid) |-> !bus_ack); // R7
   AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> bus_valid); // R3
endmodule

// File: tb/sim_hs_link_top.sv
module sim_hs_link_top;
   localparam int AW = 8, DW = 16, DEC = 2, TO = 64, BASE = 64, WORDS = 8, S = 2;
   localparam int LAT_WR  = DEC + 4*S + 4 + 1;
   localparam int LAT_RD  = LAT_WR + 1;
   localparam int LAT_ERR = DEC + TO + 1 + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic busy, done, err;
   logic [DW-1:0] rdata;
   logic bus_valid, bus_req, bus_ack;

   always #5 clk = ~clk;

   hs_link_top #(.AW(AW), .DW(DW), .DECODE_CYC(DEC), .TIMEOUT(TO), .BASE(BASE),
                 .WORDS(WORDS), .SYNC_STAGES(S)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr), .wdata(wdata),
      .busy(busy), .done(done), .err(err), .rdata(rdata),
      .bus_valid(bus_valid), .bus_req(bus_req), .bus_ack(bus_ack)
   );

   typedef struct {
      string         tag;
      logic          is_rd;
      logic          exp_err;
      logic [DW-1:0] exp_data;
      int            exp_lat;
      int            t0;
   } item_t;

   item_t         sb[$];
   logic [DW-1:0] model [WORDS];
   int            cyc = 0;
   int            nchk = 0, nfail = 0;
   bit            finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input bit ok, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected items on each done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check("R10 unexpected done", 1'b0, 1, 0);
         end else begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " latency R9"}, (cyc - it.t0) == it.exp_lat, cyc - it.t0, it.exp_lat);
            check({it.tag, " err R8"}, err == it.exp_err, err, it.exp_err);
            if (it.is_rd && !it.exp_err)
               check({it.tag, " rdata R5"}, rdata == it.exp_data, rdata, it.exp_data);
         end
      end
   end

   function automatic bit in_win(input logic [AW-1:0] a);
      return (int'(a) >= BASE) && (int'(a) < BASE + WORDS);
   endfunction

   task automatic op(input string tag, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      item_t it;
      bit h;
      h = in_win(a);
      it.tag = tag;
      it.is_rd = !w;
      it.exp_err = !h;
      it.exp_data = h ? model[int'(a) - BASE] : '0;
      it.exp_lat = !h ? LAT_ERR : (w ? LAT_WR : LAT_RD);
      it.t0 = cyc;
      sb.push_back(it);
      if (w && h) model[int'(a) - BASE] = d;
      start = 1'b1; wr = w; addr = a; wdata = d;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic op_with_stray(input logic [AW-1:0] a, input logic [DW-1:0] d);
      item_t it;
      it.tag = "R10 write";
      it.is_rd = 1'b0;
      it.exp_err = 1'b0;
      it.exp_data = '0;
      it.exp_lat = LAT_WR;
      it.t0 = cyc;
      sb.push_back(it);
      model[int'(a) - BASE] = d;
      start = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      check("R10 busy during op", busy == 1'b1, busy, 1);
      // stray command while busy: must be ignored
      start = 1'b1; wr = 1'b1; addr = 8'(BASE + 2); wdata = 16'hDEAD;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < WORDS; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 req", bus_req == 0, bus_req, 0);
      check("R1 ack", bus_ack == 0, bus_ack, 0);
      check("R1 valid/busy/done/err", {bus_valid, busy, done, err} == 4'b0,
            {bus_valid, busy, done, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after release", {bus_req, bus_ack, busy} == 3'b0, {bus_req, bus_ack, busy}, 0);

      // R3: request not before DECODE_CYC cycles of valid lines
      start = 1'b1; wr = 1'b1; addr = 8'(BASE); wdata = 16'h1234;
      begin
         item_t it;
         it.tag = "R4 first write"; it.is_rd = 0; it.exp_err = 0; it.exp_data = '0;
         it.exp_lat = LAT_WR; it.t0 = cyc;
         sb.push_back(it);
         model[0] = 16'h1234;
      end
      @(negedge clk);
      start = 1'b0;
      check("R2 valid after accept", bus_valid == 1, bus_valid, 1);
      for (int k = 1; k < DEC; k++) begin
         check("R3 req held low", bus_req == 0, bus_req, 0);
         @(negedge clk);
      end
      check("R3 req low last settle cycle", bus_req == 0, bus_req, 0);
      @(negedge clk);
      check("R3 req high after decode", bus_req == 1, bus_req, 1);
      while (!done) @(negedge clk);
      @(negedge clk);

      // R4/R5 writes and reads at both window edges
      op("R4 write top", 1'b1, 8'(BASE + WORDS - 1), 16'hBEEF);
      op("R4 write mid", 1'b1, 8'(BASE + 3), 16'h00FF);
      op("R5 read base", 1'b0, 8'(BASE), 16'h0);
      op("R5 read top", 1'b0, 8'(BASE + WORDS - 1), 16'h0);
      op("R5 read mid", 1'b0, 8'(BASE + 3), 16'h0);
      op("R5 read untouched", 1'b0, 8'(BASE + 5), 16'h0);
      op("R4 overwrite", 1'b1, 8'(BASE + 3), 16'hA5A5);
      op("R4 read overwrite", 1'b0, 8'(BASE + 3), 16'h0);

      // R8 out-of-window accesses (below and above)
      op("R8 write below", 1'b1, 8'(BASE - 1), 16'h7777);
      check("R8 ack never rose", bus_ack == 0, bus_ack, 0);
      op("R8 write above", 1'b1, 8'(BASE + WORDS), 16'h6666);
      op("R8 read above", 1'b0, 8'(BASE + WORDS), 16'h0);
      op("R8 store unchanged", 1'b0, 8'(BASE + WORDS - 1), 16'h0);

      // R10 stray start while busy
      op_with_stray(8'(BASE + 1), 16'h4242);
      op("R10 stray not stored", 1'b0, 8'(BASE + 2), 16'h0);
      op("R10 real write kept", 1'b0, 8'(BASE + 1), 16'h0);

      // R7 back-to-back: ack low when the next command starts
      check("R7 ack low before next", bus_ack == 0, bus_ack, 0);
      op("R7 back-to-back write", 1'b1, 8'(BASE + 6), 16'h0C0C);
      op("R7 back-to-back read", 1'b0, 8'(BASE + 6), 16'h0);

      repeat (3) @(negedge clk);
      check("R10 scoreboard empty", sb.size() == 0, sb.size(), 0);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule